// File: doc/BRIEF.md
# Asynchronous Data Error Trap Classifier and Status Register

This block watches the uncorrectable-error indications raised each cycle by a processor core. It decides whether they call for a trap, and which of two trap kinds that is. When a trap fires, the block updates a read-only status word that the trap handler reads afterwards.

A handler-mode control bit selects the trap kind:

- With the bit clear, an instruction-level or asynchronous error raises a single trap. A single trap records how the trapped instruction ended and the privilege level it ran at.
- With the bit set, an instruction-level, instruction-access or data-access error raises a multiple trap. A multiple trap accumulates one sticky flag per cause.

The trap requests are combinational pulses in the cycle the errors are presented. The status word changes on the following clock edge. Trap vector calculation, trap-level handling and the handler itself sit outside this block.

Top module: `async_err_trap_status`

## Requirements
- R1: With handler_mode=0, trap_single is 1 in exactly those cycles where err_insn or err_async is 1; err_iaccess and err_daccess alone raise no trap.
- R2: With handler_mode=1, trap_multi is 1 in exactly those cycles where err_insn, err_iaccess or err_daccess is 1; err_async alone raises no trap.
- R3: trap_single and trap_multi are never 1 together, and each is 1 only in a cycle where a qualifying error is present.
- R4: On a single trap, status[5:4] takes end_method (00 precise, 01 retryable not precise, 10 reserved, 11 not retryable); if wdog_timeout is 1 in that cycle, status[5:4] becomes 00 instead.
- R5: On a single trap, status[3] takes priv_prev, but becomes 1 whenever priv_corrupt is 1.
- R6: On a single trap, status[2:0] all become 0.
- R7: On a multiple trap, status[2] is set by err_daccess, status[1] by err_iaccess and status[0] by err_insn; a bit whose cause is absent keeps its value, and status[5:3] are left unchanged.
- R8: status bits above bit 5 always read 0.
- R9: The status word changes only on the clock edge that follows a trap request, and holds its value in cycles without a trap.
- R10: While rst_n is low the status word reads 0 and no trap request is asserted; after rst_n rises, trap requests remain blocked until the internal reset release has passed through its synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| handler_mode | input | 1 | 0 selects single traps, 1 selects multiple traps |
| err_insn | input | 1 | Instruction-level uncorrectable error this cycle |
| err_async | input | 1 | Asynchronous uncorrectable error this cycle |
| err_iaccess | input | 1 | Instruction-access error this cycle |
| err_daccess | input | 1 | Data-access error this cycle |
| priv_prev | input | 1 | Privilege bit immediately before the trap |
| priv_corrupt | input | 1 | Privilege state holds an uncorrectable error |
| end_method | input | 2 | End-method code of the trapped instruction |
| wdog_timeout | input | 1 | Watchdog timeout accompanies the trap |
| trap_single | output | 1 | Single trap request pulse |
| trap_multi | output | 1 | Multiple trap request pulse |
| status | output | 16 | Read-only error status word |

## Verification
Several internal faults show up only at the status port, one cycle after the trap pulse:

- A wrong sticky flag stays visible until the next single trap clears it. Long random runs of multiple traps expose any flag that sets on the wrong cause or decays.
- A wrong captured end-method or privilege value appears on the edge right after the single trap. It stays in place through idle cycles and later multiple traps.
- A misclassified trap kind shows up on the pulse outputs in the very cycle the errors are driven.

// File: rtl/aets_pkg.sv
package aets_pkg;

  // Number of per-cause sticky flags and their positions in the status word.
  localparam int unsigned NCAUSE     = 3;
  localparam int unsigned CAUSE_INSN = 0;
  localparam int unsigned CAUSE_IAE  = 1;
  localparam int unsigned CAUSE_DAE  = 2;

  // Field positions above the cause flags.
  localparam int unsigned PRIV_BIT   = 3;
  localparam int unsigned EM_LSB     = 4;
  localparam int unsigned EM_W       = 2;
  localparam int unsigned FIELD_W    = EM_LSB + EM_W;

  typedef enum logic [1:0] {
    EM_PRECISE  = 2'b00,
    EM_RETRY    = 2'b01,
    EM_RESERVED = 2'b10,
    EM_NORETRY  = 2'b11
  } end_method_e;

  typedef enum logic [1:0] {
    TRAP_NONE   = 2'b00,
    TRAP_SINGLE = 2'b01,
    TRAP_MULTI  = 2'b10
  } trap_kind_e;

endpackage

// File: rtl/aets_rst_sync.sv
module aets_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/aets_classify.sv
module aets_classify
  import aets_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             handler_mode,
  input  logic             err_insn,
  input  logic             err_async,
  input  logic             err_iaccess,
  input  logic             err_daccess,
  output trap_kind_e       trap_kind,
  output logic [NCAUSE-1:0] cause_vec
);

  logic single_cond;
  logic multi_cond;

  always_comb begin
    cause_vec              = '0;
    cause_vec[CAUSE_INSN]  = err_insn;
    cause_vec[CAUSE_IAE]   = err_iaccess;
    cause_vec[CAUSE_DAE]   = err_daccess;
  end

  always_comb begin
    single_cond = !handler_mode && (err_insn || err_async);
    multi_cond  =  handler_mode && (|cause_vec);
  end

  // Multiple wins if both ever held; the single update is then suppressed.
  always_comb begin
    if (!rst_ok) begin
      trap_kind = TRAP_NONE;
    end else if (multi_cond) begin
      trap_kind = TRAP_MULTI;
    end else if (single_cond) begin
      trap_kind = TRAP_SINGLE;
    end else begin
      trap_kind = TRAP_NONE;
    end
  end

  AST_ASYNC_NO_MULTI: assert property (@(posedge clk) disable iff (!rst_ok)
    (handler_mode && err_async && !err_insn && !err_iaccess && !err_daccess)
      |-> (trap_kind == TRAP_NONE)); // R2

  AST_ACCESS_NO_SINGLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (!handler_mode && !err_insn && !err_async)
      |-> (trap_kind == TRAP_NONE)); // R1

endmodule

// File: rtl/aets_status_reg.sv
module aets_status_reg
  import aets_pkg::*;
#(
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trap_kind_e        trap_kind,
  input  logic [NCAUSE-1:0] cause_vec,
  input  logic              priv_prev,
  input  logic              priv_corrupt,
  input  logic [EM_W-1:0]   end_method,
  input  logic              wdog_timeout,
  output logic [STAT_W-1:0] status_o
);

  localparam int unsigned RSVD_W = STAT_W - FIELD_W;

  logic [EM_W-1:0]   em_q;
  logic [EM_W-1:0]   em_d;
  logic              priv_q;
  logic              priv_d;
  logic              fld_en;
  logic [NCAUSE-1:0] cause_q;
  logic [NCAUSE-1:0] cause_d;

  always_comb begin
    fld_en = (trap_kind == TRAP_SINGLE);
    em_d   = wdog_timeout ? EM_PRECISE : end_method;
    priv_d = priv_corrupt | priv_prev;
  end

  for (genvar c = 0; c < NCAUSE; c++) begin : g_cause
    assign cause_d[c] = (trap_kind == TRAP_SINGLE) ? 1'b0 :
                        (trap_kind == TRAP_MULTI)  ? (cause_q[c] | cause_vec[c]) :
                                                     cause_q[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em_q    <= '0;
      priv_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      if (fld_en) begin
        em_q   <= em_d;
        priv_q <= priv_d;
      end
      cause_q <= cause_d;
    end
  end

  assign status_o = {{RSVD_W{1'b0}}, em_q, priv_q, cause_q};

  AST_SINGLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_kind == TRAP_SINGLE) |=> (status_o[NCAUSE-1:0] == '0)); // R6

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_kind == TRAP_MULTI) |=>
      ((status_o[NCAUSE-1:0] & $past(status_o[NCAUSE-1:0])) == $past(status_o[NCAUSE-1:0]))); // R7

  AST_MULTI_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_kind == TRAP_MULTI) |=> $stable(status_o[FIELD_W-1:PRIV_BIT])); // R7

  AST_PRIV_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_kind == TRAP_SINGLE && priv_corrupt) |=> status_o[PRIV_BIT]); // R5

  AST_WDOG_EM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_kind == TRAP_SINGLE && wdog_timeout) |=> (status_o[FIELD_W-1:EM_LSB] == EM_PRECISE)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_kind == TRAP_NONE) |=> $stable(status_o)); // R9

endmodule

// File: rtl/async_err_trap_status.sv
module async_err_trap_status
  import aets_pkg::*;
#(
  parameter int unsigned STAT_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              handler_mode,
  input  logic              err_insn,
  input  logic              err_async,
  input  logic              err_iaccess,
  input  logic              err_daccess,
  input  logic              priv_prev,
  input  logic              priv_corrupt,
  input  logic [1:0]        end_method,
  input  logic              wdog_timeout,
  output logic              trap_single,
  output logic              trap_multi,
  output logic [STAT_W-1:0] status
);

  logic              rst_sync_n;
  trap_kind_e        trap_kind;
  logic [NCAUSE-1:0] cause_vec;

  aets_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aets_classify u_cls (
    .clk          (clk),
    .rst_ok       (rst_sync_n),
    .handler_mode (handler_mode),
    .err_insn     (err_insn),
    .err_async    (err_async),
    .err_iaccess  (err_iaccess),
    .err_daccess  (err_daccess),
    .trap_kind    (trap_kind),
    .cause_vec    (cause_vec)
  );

  aets_status_reg #(.STAT_W(STAT_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .trap_kind    (trap_kind),
    .cause_vec    (cause_vec),
    .priv_prev    (priv_prev),
    .priv_corrupt (priv_corrupt),
    .end_method   (end_method),
    .wdog_timeout (wdog_timeout),
    .status_o     (status)
  );

  assign trap_single = (trap_kind == TRAP_SINGLE);
  assign trap_multi  = (trap_kind == TRAP_MULTI);

  AST_SINGLE_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_single |-> (!handler_mode && (err_insn || err_async))); // R3

  AST_MULTI_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_multi |-> (handler_mode && (err_insn || err_iaccess || err_daccess))); // R3

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(trap_single && trap_multi)); // R3

endmodule

// File: tb/sim_async_err_trap_status.sv
`timescale 1ns/1ps
module sim_async_err_trap_status;

  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         handler_mode, err_insn, err_async, err_iaccess, err_daccess;
  logic         priv_prev, priv_corrupt, wdog_timeout;
  logic [1:0]   end_method;
  logic         trap_single, trap_multi;
  logic [W-1:0] status;

  int compared   = 0;
  int mismatched = 0;
  logic [W-1:0] exp_stat;
  string        last_tag;

  always #2 clk = ~clk;

  async_err_trap_status u0 (
    .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode),
    .err_insn(err_insn), .err_async(err_async), .err_iaccess(err_iaccess),
    .err_daccess(err_daccess), .priv_prev(priv_prev), .priv_corrupt(priv_corrupt),
    .end_method(end_method), .wdog_timeout(wdog_timeout),
    .trap_single(trap_single), .trap_multi(trap_multi), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_single(input logic hm, ins, asy);
    return !hm && (ins || asy);
  endfunction

  function automatic logic exp_multi(input logic hm, ins, iae, dae);
    return hm && (ins || iae || dae);
  endfunction

  function automatic logic [W-1:0] next_stat(input logic [W-1:0] cur, input logic hm,
      ins, asy, iae, dae, pp, pc, input logic [1:0] em, input logic wd);
    logic [W-1:0] n;
    n = cur;
    if (exp_multi(hm, ins, iae, dae)) begin
      n[2] = cur[2] | dae;
      n[1] = cur[1] | iae;
      n[0] = cur[0] | ins;
    end else if (exp_single(hm, ins, asy)) begin
      n[5:4] = wd ? 2'b00 : em;
      n[3]   = pp | pc;
      n[2:0] = 3'b000;
    end
    return n;
  endfunction

  task automatic step(input logic hm, ins, asy, iae, dae, pp, pc,
                      input logic [1:0] em, input logic wd, input string tag);
    @(negedge clk);
    chk({last_tag, " status"}, status, exp_stat);
    chk("R8 reserved bits", 32'(status[W-1:6]), 32'd0);
    handler_mode = hm; err_insn = ins; err_async = asy; err_iaccess = iae;
    err_daccess = dae; priv_prev = pp; priv_corrupt = pc; end_method = em;
    wdog_timeout = wd;
    #1;
    chk({tag, " trap_single"}, 32'(trap_single), 32'(exp_single(hm, ins, asy)));
    chk({tag, " trap_multi"},  32'(trap_multi),  32'(exp_multi(hm, ins, iae, dae)));
    exp_stat = next_stat(exp_stat, hm, ins, asy, iae, dae, pp, pc, em, wd);
    last_tag = tag;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R9 idle");
  endtask

  task automatic do_reset(input logic with_err);
    @(negedge clk);
    handler_mode = 1'b0; err_insn = with_err; err_async = with_err;
    err_iaccess = 1'b0; err_daccess = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R10 status in reset", status, '0);
    chk("R10 no single in reset", 32'(trap_single), 32'd0);
    @(negedge clk);
    chk("R10 no single held in reset", 32'(trap_single), 32'd0);
    rst_n = 1'b1;
    #1;
    chk("R10 blocked during sync", 32'(trap_single), 32'd0);
    err_insn = 1'b0; err_async = 1'b0;
    repeat (3) @(negedge clk);
    exp_stat = '0;
    last_tag = "R10 after reset";
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    compared++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0;
    handler_mode = 0; err_insn = 0; err_async = 0; err_iaccess = 0; err_daccess = 0;
    priv_prev = 0; priv_corrupt = 0; end_method = 2'b00; wdog_timeout = 0;
    exp_stat = '0;
    last_tag = "R10 reset";
    do_reset(1'b0);

    // Single traps: each end-method code, privilege capture (R1, R4, R5)
    step(0, 1, 0, 0, 0, 1, 0, 2'b01, 0, "R4 single em=01");
    step(0, 0, 1, 0, 0, 0, 0, 2'b11, 0, "R4 single em=11");
    step(0, 1, 1, 0, 0, 0, 0, 2'b10, 0, "R4 single em=10");
    step(0, 0, 1, 0, 0, 0, 1, 2'b11, 1, "R5 corrupt priv wdog");
    idle();
    // Access errors under handler_mode=0 are ignored (R1)
    step(0, 0, 0, 1, 1, 1, 1, 2'b11, 0, "R1 access ignored");
    idle();
    // Multiple traps, each cause alone, then sticky (R2, R7)
    step(1, 0, 0, 0, 1, 0, 0, 2'b01, 0, "R7 multi dae");
    step(1, 0, 0, 1, 0, 1, 1, 2'b10, 1, "R7 multi iae");
    step(1, 0, 1, 0, 0, 1, 1, 2'b01, 0, "R2 async ignored");
    step(1, 1, 0, 0, 0, 0, 0, 2'b11, 0, "R7 multi insn");
    idle();
    idle();
    // Single clears the sticky flags (R6)
    step(0, 0, 1, 0, 0, 0, 0, 2'b00, 0, "R6 single clears");
    idle();

    // Random traffic (R1, R2, R3, R7, R9)
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] em;
      em = 2'($urandom);
      step(1'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom),
           ($urandom % 8) == 0, em, ($urandom % 6) == 0, "R3 random");
    end
    idle();

    // Reset mid-run with errors present (R10)
    step(1, 1, 0, 1, 1, 0, 0, 2'b00, 0, "R7 before reset");
    do_reset(1'b1);
    step(0, 1, 0, 0, 0, 1, 0, 2'b11, 0, "R4 after reset");
    idle();
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule